// File: doc/BRIEF.md
# Memory Type Range Resolver

The resolver turns a physical address range into an 8-bit memory type. Its register file holds three things: a default-type word that also carries the enable bits, a table of 88 fixed-range type bytes that covers the first megabyte, and a set of variable ranges. Each variable range is a base/mask pair. Software fills the registers through a single-cycle write port. A lookup takes a start address and an exclusive end address. It answers with either a resolved type or one of two marker codes. One marker means the unit is off. The other means the range is not covered uniformly.

A lookup is accepted only when the unit is idle. The unit then walks the variable ranges one per clock and merges every matching range under the precedence rules. At the end it picks the answer. The checks are made in this order: global disable, fixed-table hit, variable-range verdict, default type. The response is a one-cycle pulse. The latency is the same for every lookup. While a walk is in progress the write port reports not-ready, and any write offered then is dropped.

Top module: `memtype_resolver`

## Requirements
- R1: After reset the unit is idle: `busy` and `rsp_valid` are low, `wr_ready` is high, and every register is zero, so a first lookup answers 0xFF.
- R2: A request is accepted on a rising edge where `req_valid` is high and `busy` is low. `rsp_valid` then pulses for one cycle, exactly NUM_VAR rising edges later. `busy` stays high up to that edge. Any request offered while busy is ignored.
- R3: The default word (write kind 0) has bit 10 as the fixed enable and bit 11 as the variable enable. With both bits clear the answer is 0xFF.
- R4: With bit 10 set and start below 0x100000, the answer is the fixed byte picked by the start address alone. Below 0x80000 the index is start>>16. From 0x80000 to 0xBFFFF it is 8+((start-0x80000)>>14). From 0xC0000 to 0xFFFFF it is 24+((start-0xC0000)>>12). Fixed bytes are written with kind 1, with the byte index in `wr_idx` and the type in data bits 7:0.
- R5: The end address is exclusive: end-1 is the last byte that is tested.
- R6: A variable range (base written with kind 2, mask with kind 3, both indexed by `wr_idx`) takes part only when bit 11 of its mask is set. An address matches when (addr & mask) equals (base & mask), and bits 11:0 of both words are ignored.
- R7: If start and end-1 disagree on matching a valid range, the answer is 0xFE.
- R8: The type of a variable range is bits 7:0 of its base word.
- R9: Among several matching ranges, if any is uncachable (0), the answer is 0.
- R10: Write-back (6) merged with write-through (4) gives 4. Any other pair of differing types gives 0.
- R11: With the variable enable clear, or with no valid range matching, the answer is bits 7:0 of the default word.
- R12: While `busy` is high, `wr_ready` is low and an offered write is not applied.
- R13: The ranges are visited in index order. The first range that forces 0xFE or a clash-to-uncachable decides the answer, and later ranges do not change it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write request |
| wr_ready | output | 1 | High when a write is accepted this cycle |
| wr_kind | input | 2 | 0 default word, 1 fixed byte, 2 range base, 3 range mask |
| wr_idx | input | IDX_W (7) | Fixed byte or range index |
| wr_data | input | ADDR_W (36) | Write data |
| req_valid | input | 1 | Lookup request |
| req_start | input | ADDR_W | First byte of the range |
| req_end | input | ADDR_W | One past the last byte |
| busy | output | 1 | Walk in progress |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_type | output | 8 | Resolved type or marker code |

## Verification
The request is taken at acceptance edge 0. Range k is then evaluated at edge k+1, and the response is registered at edge NUM_VAR. The bench drives inputs on falling edges. At the falling edge after edge NUM_VAR-1 it requires `busy` high and no strobe. At the falling edge after edge NUM_VAR it requires the strobe and reads the type. A write or a second request offered during the walk is held for a known number of edges. The following lookup shows whether that stimulus left any trace.

// File: rtl/memtype_pkg.sv
package memtype_pkg;

   typedef enum logic [1:0] {
      WK_DEFAULT = 2'd0,
      WK_FIXED   = 2'd1,
      WK_BASE    = 2'd2,
      WK_MASK    = 2'd3
   } wr_kind_e;

   typedef enum logic [1:0] {
      V_OPEN     = 2'd0,
      V_PARTIAL  = 2'd1,
      V_UNCACHED = 2'd2
   } verdict_e;

   localparam logic [7:0] MT_UC       = 8'h00;
   localparam logic [7:0] MT_WT       = 8'h04;
   localparam logic [7:0] MT_WB       = 8'h06;
   localparam logic [7:0] MT_PARTIAL  = 8'hFE;
   localparam logic [7:0] MT_DISABLED = 8'hFF;

   localparam int PAGE_LSB      = 12;
   localparam int FIX_EN_BIT    = 10;
   localparam int VAR_EN_BIT    = 11;
   localparam int RANGE_VLD_BIT = 11;

   localparam int FIX64_SLOTS = 8;
   localparam int FIX16_SLOTS = 16;
   localparam int FIX4_SLOTS  = 64;
   localparam int FIX_SLOTS   = FIX64_SLOTS + FIX16_SLOTS + FIX4_SLOTS;
   localparam int FIX_IDX_W   = $clog2(FIX_SLOTS);

   // bit 8 set: the pair cannot be reconciled, walk must stop as uncachable
   function automatic logic [8:0] merge_types(input logic [7:0] a, input logic [7:0] b);
      if (a == MT_UC || b == MT_UC)                              return {1'b1, MT_UC};
      if ((a == MT_WB && b == MT_WT) || (a == MT_WT && b == MT_WB)) return {1'b0, MT_WT};
      if (a != b)                                                return {1'b1, MT_UC};
      return {1'b0, a};
   endfunction

endpackage

// File: rtl/memtype_regfile.sv
module memtype_regfile
   import memtype_pkg::*;
#(
   parameter  int ADDR_W    = 36,
   parameter  int NUM_VAR   = 8,
   parameter  bit HAS_FIXED = 1'b1,
   parameter  int IDX_W     = 7,
   localparam int SEL_W     = $clog2(NUM_VAR),
   localparam int PG_W      = ADDR_W - PAGE_LSB
)(
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 busy,
   input  logic                 wr_fire,
   input  wr_kind_e             wr_kind,
   input  logic [IDX_W-1:0]     wr_idx,
   input  logic [ADDR_W-1:0]    wr_data,
   output logic [7:0]           def_type,
   output logic                 fix_en,
   output logic                 var_en,
   input  logic [SEL_W-1:0]     var_sel,
   output logic [PG_W-1:0]      var_base_pg,
   output logic [PG_W-1:0]      var_mask_pg,
   output logic [7:0]           var_type,
   output logic                 var_valid,
   input  logic [FIX_IDX_W-1:0] fix_sel,
   output logic [7:0]           fix_type
);

   logic [9:0] def_q;
   logic       unused_wr_bits;
   assign unused_wr_bits = ^wr_data[9:8];

   always_ff @(posedge clk) begin
      if (!rst_n)
         def_q <= '0;
      else if (wr_fire && wr_kind == WK_DEFAULT)
         def_q <= {wr_data[VAR_EN_BIT], wr_data[FIX_EN_BIT], wr_data[7:0]};
   end

   assign def_type = def_q[7:0];
   assign fix_en   = def_q[8];
   assign var_en   = def_q[9];

   logic [PG_W-1:0] base_arr [NUM_VAR];
   logic [PG_W-1:0] mask_arr [NUM_VAR];
   logic [7:0]      type_arr [NUM_VAR];
   logic            vld_arr  [NUM_VAR];

   for (genvar gi = 0; gi < NUM_VAR; gi++) begin : g_range
      logic [PG_W-1:0] b_pg, m_pg;
      logic [7:0]      ty;
      logic            vld;
      wire hit = wr_fire && wr_idx == IDX_W'(gi);
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            b_pg <= '0;
            m_pg <= '0;
            ty   <= '0;
            vld  <= 1'b0;
         end else if (hit && wr_kind == WK_BASE) begin
            b_pg <= wr_data[ADDR_W-1:PAGE_LSB];
            ty   <= wr_data[7:0];
         end else if (hit && wr_kind == WK_MASK) begin
            m_pg <= wr_data[ADDR_W-1:PAGE_LSB];
            vld  <= wr_data[RANGE_VLD_BIT];
         end
      end
      assign base_arr[gi] = b_pg;
      assign mask_arr[gi] = m_pg;
      assign type_arr[gi] = ty;
      assign vld_arr[gi]  = vld;
   end

   assign var_base_pg = base_arr[var_sel];
   assign var_mask_pg = mask_arr[var_sel];
   assign var_type    = type_arr[var_sel];
   assign var_valid   = vld_arr[var_sel];

   if (HAS_FIXED) begin : g_fixed
      logic [7:0] fix_q [FIX_SLOTS];
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            for (int i = 0; i < FIX_SLOTS; i++) fix_q[i] <= '0;
         end else if (wr_fire && wr_kind == WK_FIXED && wr_idx < IDX_W'(FIX_SLOTS)) begin
            fix_q[wr_idx] <= wr_data[7:0];
         end
      end
      assign fix_type = fix_q[fix_sel];
   end else begin : g_nofixed
      logic unused_fix_sel;
      assign unused_fix_sel = ^fix_sel;
      assign fix_type = '0;
   end

   // R12: writes are held off for the whole walk
   p_def_frozen_r12: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> $stable(def_q));

endmodule

// File: rtl/memtype_fixed_index.sv
module memtype_fixed_index
   import memtype_pkg::*;
#(
   parameter  int ADDR_W = 36,
   localparam int PG_W   = ADDR_W - PAGE_LSB
)(
   input  logic [PG_W-1:0]      start_pg,
   output logic                 low_mb,
   output logic [FIX_IDX_W-1:0] idx
);

   // page bit k is address bit k+12
   assign low_mb = ~|start_pg[PG_W-1:8];

   always_comb begin
      case (start_pg[7:6])
         2'b10:   idx = FIX_IDX_W'(FIX64_SLOTS) + FIX_IDX_W'(start_pg[5:2]);
         2'b11:   idx = FIX_IDX_W'(FIX64_SLOTS + FIX16_SLOTS) + FIX_IDX_W'(start_pg[5:0]);
         default: idx = FIX_IDX_W'(start_pg[6:4]);
      endcase
   end

   // R4: the three granularities stay inside the table
   always_comb begin
      a_idx_in_table_r4: assert (idx < FIX_IDX_W'(FIX_SLOTS));
   end

endmodule

// File: rtl/memtype_var_scan.sv
module memtype_var_scan
   import memtype_pkg::*;
#(
   parameter  int ADDR_W  = 36,
   parameter  int NUM_VAR = 8,
   localparam int SEL_W   = $clog2(NUM_VAR),
   localparam int PG_W    = ADDR_W - PAGE_LSB
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [ADDR_W-1:0] req_start,
   input  logic [ADDR_W-1:0] req_end,
   output logic              busy,
   output logic              rsp_valid,
   output logic [7:0]        rsp_type,
   output logic [PG_W-1:0]   cur_start_pg,
   output logic [SEL_W-1:0]  var_sel,
   input  logic [PG_W-1:0]   var_base_pg,
   input  logic [PG_W-1:0]   var_mask_pg,
   input  logic [7:0]        var_type,
   input  logic              var_valid,
   input  logic [7:0]        def_type,
   input  logic              fix_en,
   input  logic              var_en,
   input  logic              fix_hit,
   input  logic [7:0]        fix_type
);

   logic              busy_q;
   logic [SEL_W-1:0]  sel_q;
   logic [PG_W-1:0]   start_q, last_q;
   verdict_e          verdict_q, verdict_n;
   logic              have_q, have_n;
   logic [7:0]        acc_q, acc_n, final_type;
   logic [ADDR_W-1:0] last_addr;
   logic              unused_low;

   assign last_addr  = req_end - ADDR_W'(1);
   assign unused_low = ^{req_start[PAGE_LSB-1:0], last_addr[PAGE_LSB-1:0]};

   wire last_sel = (sel_q == SEL_W'(NUM_VAR - 1));
   wire s_in     = (start_q & var_mask_pg) == (var_base_pg & var_mask_pg);
   wire e_in     = (last_q  & var_mask_pg) == (var_base_pg & var_mask_pg);

   always_comb begin
      logic [8:0] mr;
      verdict_n = verdict_q;
      have_n    = have_q;
      acc_n     = acc_q;
      mr        = merge_types(acc_q, var_type);
      if (verdict_q == V_OPEN && var_valid) begin
         if (s_in != e_in) begin
            verdict_n = V_PARTIAL;
         end else if (s_in) begin
            if (!have_q) begin
               have_n = 1'b1;
               acc_n  = var_type;
            end else begin
               acc_n = mr[7:0];
               if (mr[8]) verdict_n = V_UNCACHED;
            end
         end
      end
   end

   always_comb begin
      if (!fix_en && !var_en)         final_type = MT_DISABLED;
      else if (fix_en && fix_hit)     final_type = fix_type;
      else if (!var_en)               final_type = def_type;
      else if (verdict_n == V_PARTIAL)  final_type = MT_PARTIAL;
      else if (verdict_n == V_UNCACHED) final_type = MT_UC;
      else if (have_n)                final_type = acc_n;
      else                            final_type = def_type;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy_q    <= 1'b0;
         sel_q     <= '0;
         start_q   <= '0;
         last_q    <= '0;
         verdict_q <= V_OPEN;
         have_q    <= 1'b0;
         acc_q     <= '0;
         rsp_valid <= 1'b0;
         rsp_type  <= '0;
      end else begin
         rsp_valid <= 1'b0;
         if (!busy_q) begin
            if (req_valid) begin
               busy_q    <= 1'b1;
               sel_q     <= '0;
               start_q   <= req_start[ADDR_W-1:PAGE_LSB];
               last_q    <= last_addr[ADDR_W-1:PAGE_LSB];
               verdict_q <= V_OPEN;
               have_q    <= 1'b0;
               acc_q     <= '0;
            end
         end else begin
            verdict_q <= verdict_n;
            have_q    <= have_n;
            acc_q     <= acc_n;
            if (last_sel) begin
               busy_q    <= 1'b0;
               rsp_valid <= 1'b1;
               rsp_type  <= final_type;
            end else begin
               sel_q <= sel_q + SEL_W'(1);
            end
         end
      end
   end

   assign busy         = busy_q;
   assign var_sel      = sel_q;
   assign cur_start_pg = start_q;

   // R2: one range per clock, strobe only at the end of a walk
   p_scan_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
      busy_q && !last_sel |=> busy_q && sel_q == $past(sel_q) + SEL_W'(1));
   p_rsp_after_walk_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rsp_valid) |-> $past(busy_q) && !busy_q);
   p_rsp_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |=> !rsp_valid);
   // R3: disabled unit answers the marker
   p_disabled_code_r3: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid && !fix_en && !var_en |-> rsp_type == MT_DISABLED);
   // R13: an early verdict is not overwritten by later ranges
   p_verdict_sticky_r13: assert property (@(posedge clk) disable iff (!rst_n)
      busy_q && !last_sel && verdict_q != V_OPEN |=> verdict_q == $past(verdict_q));

endmodule

// File: rtl/memtype_resolver.sv
module memtype_resolver
   import memtype_pkg::*;
#(
   parameter  int ADDR_W    = 36,
   parameter  int NUM_VAR   = 8,
   parameter  bit HAS_FIXED = 1'b1,
   localparam int IDX_W     = $clog2(FIX_SLOTS > NUM_VAR ? FIX_SLOTS : NUM_VAR)
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   output logic              wr_ready,
   input  logic [1:0]        wr_kind,
   input  logic [IDX_W-1:0]  wr_idx,
   input  logic [ADDR_W-1:0] wr_data,
   input  logic              req_valid,
   input  logic [ADDR_W-1:0] req_start,
   input  logic [ADDR_W-1:0] req_end,
   output logic              busy,
   output logic              rsp_valid,
   output logic [7:0]        rsp_type
);

   localparam int SEL_W = $clog2(NUM_VAR);
   localparam int PG_W  = ADDR_W - PAGE_LSB;

   if (ADDR_W < 21 || ADDR_W > 64) begin : g_bad_addr_w
      $error("memtype_resolver: ADDR_W must lie in 21..64");
   end
   if (NUM_VAR < 2) begin : g_bad_num_var
      $error("memtype_resolver: NUM_VAR must be at least 2");
   end

   logic                 wr_fire;
   logic [7:0]           def_type, var_type, fix_type;
   logic                 fix_en, var_en, var_valid, low_mb;
   logic [SEL_W-1:0]     var_sel;
   logic [PG_W-1:0]      var_base_pg, var_mask_pg, cur_start_pg;
   logic [FIX_IDX_W-1:0] fix_idx;

   assign wr_ready = ~busy;
   assign wr_fire  = wr_en & ~busy;

   memtype_regfile #(
      .ADDR_W(ADDR_W), .NUM_VAR(NUM_VAR), .HAS_FIXED(HAS_FIXED), .IDX_W(IDX_W)
   ) u_regs (
      .clk, .rst_n, .busy, .wr_fire,
      .wr_kind     (wr_kind_e'(wr_kind)),
      .wr_idx, .wr_data,
      .def_type, .fix_en, .var_en,
      .var_sel, .var_base_pg, .var_mask_pg, .var_type, .var_valid,
      .fix_sel     (fix_idx),
      .fix_type
   );

   memtype_fixed_index #(.ADDR_W(ADDR_W)) u_fix_idx (
      .start_pg (cur_start_pg),
      .low_mb,
      .idx      (fix_idx)
   );

   memtype_var_scan #(.ADDR_W(ADDR_W), .NUM_VAR(NUM_VAR)) u_scan (
      .clk, .rst_n, .req_valid, .req_start, .req_end,
      .busy, .rsp_valid, .rsp_type, .cur_start_pg,
      .var_sel, .var_base_pg, .var_mask_pg, .var_type, .var_valid,
      .def_type, .fix_en, .var_en,
      .fix_hit  (HAS_FIXED && low_mb),
      .fix_type
   );

   // R12: not-ready exactly while a walk runs
   p_wr_stall_r12: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> !wr_ready);

endmodule

// File: tb/tb_memtype_resolver.sv
`timescale 1ns/1ps
module tb_memtype_resolver;

   localparam int AW = 36;
   localparam int NV = 8;

   logic          clk = 1'b0, rst_n = 1'b0;
   logic          wr_en = 1'b0, req_valid = 1'b0;
   logic [1:0]    wr_kind = '0;
   logic [6:0]    wr_idx = '0;
   logic [AW-1:0] wr_data = '0, req_start = '0, req_end = '0;
   logic          wr_ready, busy, rsp_valid;
   logic [7:0]    rsp_type;

   memtype_resolver #(.ADDR_W(AW), .NUM_VAR(NV), .HAS_FIXED(1'b1)) dut (.*);

   always #2 clk = ~clk;

   int n_checks = 0, n_err = 0;
   logic [AW-1:0] sb_def;
   logic [AW-1:0] sb_base [NV];
   logic [AW-1:0] sb_mask [NV];
   logic [7:0]    sb_fix  [88];

   task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic summary();
      $display("Result: errors=%0d of %0d checks", n_err, n_checks);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_err++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      summary();
   end

   task automatic wr(input logic [1:0] k, input int idx, input logic [AW-1:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_kind = k; wr_idx = 7'(idx); wr_data = d;
      @(posedge clk);
      @(negedge clk);
      wr_en = 1'b0;
      case (k)
         2'd0: sb_def = d;
         2'd1: sb_fix[idx] = d[7:0];
         2'd2: sb_base[idx] = d;
         default: sb_mask[idx] = d;
      endcase
   endtask

   task automatic set_range(input int i, input logic [AW-1:0] base, input logic [AW-1:0] size,
                            input logic [7:0] ty, input logic vld);
      wr(2'd2, i, base | AW'(ty));
      wr(2'd3, i, (~(size - AW'(1)) & ~AW'(36'hFFF)) | (vld ? AW'(36'h800) : AW'(0)));
   endtask

   // leaves the bench at the falling edge after the acceptance edge, request dropped
   task automatic start_req(input logic [AW-1:0] s, input logic [AW-1:0] e);
      @(negedge clk);
      req_valid = 1'b1; req_start = s; req_end = e;
      @(posedge clk);
      @(negedge clk);
      req_valid = 1'b0;
   endtask

   task automatic wait_rsp(input int done, output logic [7:0] t);
      repeat (NV - 1 - done) @(posedge clk);
      @(negedge clk);
      check("R2 busy before strobe", {6'd0, busy, rsp_valid}, 8'h02);
      @(posedge clk);
      @(negedge clk);
      check("R2 strobe on edge NUM_VAR", {7'd0, rsp_valid}, 8'h01);
      t = rsp_type;
   endtask

   task automatic lookup(input logic [AW-1:0] s, input logic [AW-1:0] e, output logic [7:0] t);
      start_req(s, e);
      wait_rsp(0, t);
   endtask

   function automatic int fix_index(input logic [AW-1:0] s);
      if (s < 36'h80000) return int'(s >> 16);
      if (s < 36'hC0000) return 8 + int'((s - 36'h80000) >> 14);
      return 24 + int'((s - 36'hC0000) >> 12);
   endfunction

   function automatic logic [7:0] model(input logic [AW-1:0] s, input logic [AW-1:0] e);
      logic [AW-1:0] l = e - 1, m;
      logic have = 1'b0, si, ei;
      logic [7:0] acc = 8'h00, t;
      if (!sb_def[10] && !sb_def[11]) return 8'hFF;
      if (sb_def[10] && s < 36'h100000) return sb_fix[fix_index(s)];
      if (!sb_def[11]) return sb_def[7:0];
      for (int i = 0; i < NV; i++) begin
         if (sb_mask[i][11]) begin
            m  = sb_mask[i] & ~AW'(36'hFFF);
            si = (s & m) == (sb_base[i] & m);
            ei = (l & m) == (sb_base[i] & m);
            t  = sb_base[i][7:0];
            if (si != ei) return 8'hFE;
            if (si) begin
               if (!have) begin have = 1'b1; acc = t; end
               else if (acc == 8'h00 || t == 8'h00) return 8'h00;
               else if ((acc == 8'h06 && t == 8'h04) || (acc == 8'h04 && t == 8'h06)) acc = 8'h04;
               else if (acc != t) return 8'h00;
            end
         end
      end
      return have ? acc : sb_def[7:0];
   endfunction

   initial begin
      logic [7:0] t;
      logic [AW-1:0] s;
      sb_def = '0;
      for (int i = 0; i < NV; i++) begin sb_base[i] = '0; sb_mask[i] = '0; end
      for (int i = 0; i < 88; i++) sb_fix[i] = '0;

      repeat (3) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;
      // R1 reset state
      check("R1 idle after reset", {5'd0, busy, rsp_valid, wr_ready}, 8'h01);
      lookup(36'h0, 36'h1000, t);
      check("R1 first lookup", t, 8'hFF);

      // R4 fixed table sweep over every 4 KiB page of the first megabyte
      for (int i = 0; i < 88; i++) wr(2'd1, i, AW'((i * 37 + 11) & 8'hFF));
      wr(2'd0, 0, 36'h400 | 36'h02);
      for (int p = 0; p < 256; p++) begin
         s = AW'(p) << 12;
         lookup(s, s + 36'h1000, t);
         check("R4 fixed slot", t, sb_fix[fix_index(s)]);
      end
      lookup(36'h7FFFF, 36'h200000, t);
      check("R4 last 64K slot, start only", t, sb_fix[7]);
      lookup(36'hBFFFF, 36'hC0001, t);
      check("R4 last 16K slot", t, sb_fix[23]);
      lookup(36'hFFFFF, 36'h100001, t);
      check("R4 last 4K slot", t, sb_fix[87]);

      // variable ranges
      set_range(0, 36'h100000, 36'h100000, 8'h06, 1'b1);
      set_range(1, 36'h180000, 36'h080000, 8'h04, 1'b1);
      set_range(2, 36'h400000, 36'h100000, 8'h01, 1'b1);
      set_range(3, 36'h440000, 36'h040000, 8'h05, 1'b1);
      set_range(4, 36'h800000000, 36'h10000, 8'h00, 1'b1);
      set_range(5, 36'h800000000, 36'h1000, 8'h06, 1'b1);
      set_range(6, 36'h600000, 36'h1000, 8'h06, 1'b1);
      set_range(7, 36'h440000, 36'h1000, 8'h06, 1'b1);
      wr(2'd0, 0, 36'hC00 | 36'h02);

      // R6 R8 R9 R10 R11 sweep against the arithmetic model
      for (int p = 16; p < 128; p++) begin
         for (int k = 0; k < 3; k++) begin
            logic [AW-1:0] len;
            len = (k == 0) ? 36'h1000 : (k == 1) ? 36'h40000 : 36'h100000;
            s = AW'(p) << 16;
            lookup(s, s + len, t);
            check("R6 R10 variable sweep", t, model(s, s + len));
         end
      end

      lookup(36'h180000, 36'h200000, t);
      check("R5 exclusive end, WB with WT", t, 8'h04);
      lookup(36'h1F0000, 36'h210000, t);
      check("R7 partial cover", t, 8'hFE);
      lookup(36'h400000, 36'h401000, t);
      check("R8 type from base bits 7:0", t, 8'h01);
      lookup(36'h800000000, 36'h800001000, t);
      check("R9 uncachable wins over WB", t, 8'h00);
      lookup(36'h440000, 36'h441000, t);
      check("R10 differing types give UC", t, 8'h00);
      lookup(36'h440000, 36'h442000, t);
      check("R13 earlier clash beats later partial", t, 8'h00);
      lookup(36'h600000, 36'h601000, t);
      check("R11 equal types kept", t, 8'h06);
      lookup(36'h900000, 36'h901000, t);
      check("R11 no match gives default", t, 8'h02);

      set_range(5, 36'h900000000, 36'h1000, 8'h06, 1'b0);
      lookup(36'h900000000, 36'h900001000, t);
      check("R6 invalid range ignored", t, 8'h02);
      set_range(5, 36'h900000000, 36'h1000, 8'h06, 1'b1);
      lookup(36'h900000000, 36'h900001000, t);
      check("R6 valid range used", t, 8'h06);

      wr(2'd0, 0, 36'h800 | 36'h02);
      lookup(36'h0, 36'h1000, t);
      check("R4 fixed disabled falls to variable", t, 8'h02);
      wr(2'd0, 0, 36'h400 | 36'h03);
      lookup(36'h100000, 36'h101000, t);
      check("R11 variable disabled gives default", t, 8'h03);
      wr(2'd0, 0, 36'h0 | 36'h03);
      lookup(36'h100000, 36'h101000, t);
      check("R3 both enables clear", t, 8'hFF);

      // R12 write offered mid-walk is dropped
      wr(2'd0, 0, 36'hC00 | 36'h02);
      start_req(36'h900000, 36'h901000);
      wr_en = 1'b1; wr_kind = 2'd0; wr_idx = '0; wr_data = 36'hC00 | 36'h07;
      @(posedge clk);
      @(negedge clk);
      check("R12 not ready while busy", {7'd0, wr_ready}, 8'h00);
      wr_en = 1'b0;
      wait_rsp(1, t);
      check("R12 walk result unchanged", t, 8'h02);
      lookup(36'h900000, 36'h901000, t);
      check("R12 dropped write not applied", t, 8'h02);

      // R2 request while busy is ignored
      start_req(36'h400000, 36'h401000);
      req_valid = 1'b1; req_start = 36'h600000; req_end = 36'h601000;
      @(posedge clk);
      @(negedge clk);
      req_valid = 1'b0;
      wait_rsp(1, t);
      check("R2 first request answered", t, 8'h01);
      @(negedge clk);
      check("R2 second request not started", {6'd0, busy, rsp_valid}, 8'h00);

      summary();
   end

endmodule